// File: doc/BRIEF.md
# Two-Level SATA Interrupt Aggregator

This block gathers the interrupt sources of a storage host controller into one level interrupt line. Up to two groups of four SATA ports each feed per-port error lines, per-port done lines and one coalesced-done line per group. A separate set of host bus error events feeds a second cause register with its own mask. The unmasked OR of that second register shows up as one summary bit in the main cause vector.

Software sees four 32-bit registers through a simple word-addressed read/write port. The main cause register is a read-only image of the source lines. The main mask register picks which cause bits may raise the interrupt. Bus error events are sticky in the secondary cause register until software clears them, by writing a word whose zero bits mark the bits to drop. The number of populated groups is a parameter, 1 or 2. Bits that belong to no source always read as zero.

Top module: `sata_irq_agg`

## Requirements
- R1: One clock after it is sampled, the error line of port p in group h (input index 4*h+p) appears at main cause bit 2*p+9*h.
- R2: One clock after it is sampled, the done line of port p in group h (input index 4*h+p) appears at main cause bit 2*p+9*h+1.
- R3: One clock after it is sampled, the coalesced-done line of group h appears at main cause bit 9*h+8.
- R4: Main cause bit 18 reads 1 exactly when the secondary cause and the secondary mask share a set bit.
- R5: A bus error event sets its secondary cause bit, and the bit stays set until it is cleared. A write to the secondary cause register (address 2) clears each bit written as 0 and leaves each bit written as 1 unchanged. An event in the same cycle as the write takes priority and sets its bit.
- R6: The main mask register (address 1) stores every implemented bit on write and reads back what was written. Changing one bit by read-modify-write leaves the other bits as they were.
- R7: The interrupt output is high exactly while (main cause & main mask) is nonzero. It responds in the same cycle as the register contents.
- R8: Main cause and main mask bits 19 to 31 read as 0. With one populated group, bits 9 to 17 also read as 0, whatever is written or driven.
- R9: Writes to the main cause register (address 0) have no effect.
- R10: After reset, every register reads 0 and the interrupt output is low.
- R11: The secondary mask register (address 3) stores and reads back its full width. Reads of the secondary registers are zero-extended.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| port_err_i | input | 8 | Per-port error lines, index 4*group+port |
| port_done_i | input | 8 | Per-port done lines, index 4*group+port |
| coal_done_i | input | 2 | Per-group coalesced-done lines |
| bus_err_i | input | BUS_ERR_W | Bus error event lines, sticky in the secondary cause |
| reg_addr_i | input | 2 | Word address: 0 main cause, 1 main mask, 2 secondary cause, 3 secondary mask |
| reg_wr_i | input | 1 | Write strobe |
| reg_wdata_i | input | 32 | Write data |
| reg_rdata_o | output | 32 | Read data for reg_addr_i (combinational) |
| irq_o | output | 1 | Level interrupt output |

## Verification
The hardest case to reach from the ports is the secondary cause register when a clear write and a new event land in the same cycle. The bench drives a bus error event during the cycle in which it writes all zeros, then checks that the event bit survives. Each of the eight secondary bits is also set on its own, paired with a mask that selects only that bit, and then cleared by writing its complement. This shows the summary bit 18 following every bit separately. The port mapping is covered by driving each of the 18 source lines alone on both a two-group and a one-group instance. For every line, the bench checks the cause word and the interrupt with the mask bit set and with it cleared.

// File: rtl/sata_irq_pkg.sv
package sata_irq_pkg;

    localparam int MAX_GROUPS  = 2;
    localparam int GROUP_PORTS = 4;
    localparam int SLICE_W     = 9;
    localparam int BUSERR_BIT  = 18;
    localparam int REG_W       = 32;
    localparam int SRC_BITS    = MAX_GROUPS * SLICE_W;

    typedef enum logic [1:0] {
        RA_MAIN_CAUSE = 2'd0,
        RA_MAIN_MASK  = 2'd1,
        RA_SEC_CAUSE  = 2'd2,
        RA_SEC_MASK   = 2'd3
    } reg_addr_e;

    function automatic logic [REG_W-1:0] implemented_bits(input int groups);
        logic [REG_W-1:0] v;
        v = '0;
        for (int h = 0; h < MAX_GROUPS; h++) begin
            if (h < groups) begin
                for (int b = 0; b < SLICE_W; b++) begin
                    v[h*SLICE_W + b] = 1'b1;
                end
            end
        end
        v[BUSERR_BIT] = 1'b1;
        return v;
    endfunction

endpackage

// File: rtl/sata_irq_map.sv
module sata_irq_map
    import sata_irq_pkg::*;
#(
    parameter int NUM_GROUPS = 2
) (
    input  logic                                clk,
    input  logic                                rst_n,
    input  logic [MAX_GROUPS*GROUP_PORTS-1:0]   port_err_i,
    input  logic [MAX_GROUPS*GROUP_PORTS-1:0]   port_done_i,
    input  logic [MAX_GROUPS-1:0]               coal_done_i,
    output logic [SRC_BITS-1:0]                 src_cause_o
);

    typedef struct packed {
        logic [SRC_BITS-1:0] bits;
    } map_state_t;

    map_state_t st_d, st_q;

    always_comb begin
        st_d = '0;
        for (int h = 0; h < MAX_GROUPS; h++) begin
            for (int p = 0; p < GROUP_PORTS; p++) begin
                st_d.bits[h*SLICE_W + 2*p]     = (h < NUM_GROUPS) && port_err_i[h*GROUP_PORTS + p];
                st_d.bits[h*SLICE_W + 2*p + 1] = (h < NUM_GROUPS) && port_done_i[h*GROUP_PORTS + p];
            end
            st_d.bits[h*SLICE_W + SLICE_W - 1] = (h < NUM_GROUPS) && coal_done_i[h];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign src_cause_o = st_q.bits;

    // R1: port 0 error line lands at bit 0 one clock later
    a_r1_err_capture: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> (src_cause_o[0] == $past(port_err_i[0])));

    // R3: group 0 coalesced-done lands at bit 8 one clock later
    a_r3_coal_capture: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> (src_cause_o[8] == $past(coal_done_i[0])));

endmodule

// File: rtl/sata_irq_sec.sv
module sata_irq_sec #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] evt_i,
    input  logic         cause_wr_i,
    input  logic         mask_wr_i,
    input  logic [W-1:0] wdata_i,
    output logic [W-1:0] cause_o,
    output logic [W-1:0] mask_o,
    output logic         summary_o
);

    typedef struct packed {
        logic [W-1:0] cause;
        logic [W-1:0] mask;
    } sec_state_t;

    sec_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (cause_wr_i) st_d.cause = st_q.cause & wdata_i;
        st_d.cause = st_d.cause | evt_i;
        if (mask_wr_i)  st_d.mask = wdata_i;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign cause_o   = st_q.cause;
    assign mask_o    = st_q.mask;
    assign summary_o = |(st_q.cause & st_q.mask);

    // R5: with no write and no event the cause stays put
    a_r5_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        (!cause_wr_i && evt_i == '0) |=> $stable(cause_o));

    // R5: bits written as zero and not re-set are gone after the write
    a_r5_clear: assert property (@(posedge clk) disable iff (!rst_n)
        cause_wr_i |=> ((cause_o & ~$past(wdata_i) & ~$past(evt_i)) == '0));

    // R5: an event always leaves its bit set
    a_r5_set_wins: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> ((cause_o & $past(evt_i)) == $past(evt_i)));

endmodule

// File: rtl/sata_irq_agg.sv
module sata_irq_agg
    import sata_irq_pkg::*;
#(
    parameter int NUM_GROUPS = 2,
    parameter int BUS_ERR_W  = 8
) (
    input  logic                               clk,
    input  logic                               rst_n,
    input  logic [MAX_GROUPS*GROUP_PORTS-1:0]  port_err_i,
    input  logic [MAX_GROUPS*GROUP_PORTS-1:0]  port_done_i,
    input  logic [MAX_GROUPS-1:0]              coal_done_i,
    input  logic [BUS_ERR_W-1:0]               bus_err_i,
    input  logic [1:0]                         reg_addr_i,
    input  logic                               reg_wr_i,
    input  logic [REG_W-1:0]                   reg_wdata_i,
    output logic [REG_W-1:0]                   reg_rdata_o,
    output logic                               irq_o
);

    localparam logic [REG_W-1:0] VALID = implemented_bits(NUM_GROUPS);

    typedef struct packed {
        logic [REG_W-1:0] mask;
    } top_state_t;

    top_state_t st_d, st_q;

    logic [SRC_BITS-1:0]  src_cause;
    logic [BUS_ERR_W-1:0] sec_cause, sec_mask;
    logic                 sec_summary;
    logic [REG_W-1:0]     main_cause;
    logic                 sec_cause_wr, sec_mask_wr;

    assign sec_cause_wr = reg_wr_i && (reg_addr_i == RA_SEC_CAUSE);
    assign sec_mask_wr  = reg_wr_i && (reg_addr_i == RA_SEC_MASK);

    sata_irq_map #(.NUM_GROUPS(NUM_GROUPS)) u_map (
        .clk         (clk),
        .rst_n       (rst_n),
        .port_err_i  (port_err_i),
        .port_done_i (port_done_i),
        .coal_done_i (coal_done_i),
        .src_cause_o (src_cause)
    );

    sata_irq_sec #(.W(BUS_ERR_W)) u_sec (
        .clk        (clk),
        .rst_n      (rst_n),
        .evt_i      (bus_err_i),
        .cause_wr_i (sec_cause_wr),
        .mask_wr_i  (sec_mask_wr),
        .wdata_i    (reg_wdata_i[BUS_ERR_W-1:0]),
        .cause_o    (sec_cause),
        .mask_o     (sec_mask),
        .summary_o  (sec_summary)
    );

    always_comb begin
        main_cause             = '0;
        main_cause[SRC_BITS-1:0] = src_cause;
        main_cause[BUSERR_BIT] = sec_summary;
        main_cause             = main_cause & VALID;
    end

    always_comb begin
        st_d = st_q;
        if (reg_wr_i && reg_addr_i == RA_MAIN_MASK) st_d.mask = reg_wdata_i & VALID;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    always_comb begin
        reg_rdata_o = '0;
        case (reg_addr_i)
            RA_MAIN_CAUSE: reg_rdata_o = main_cause;
            RA_MAIN_MASK:  reg_rdata_o = st_q.mask;
            RA_SEC_CAUSE:  reg_rdata_o[BUS_ERR_W-1:0] = sec_cause;
            default:       reg_rdata_o[BUS_ERR_W-1:0] = sec_mask;
        endcase
    end

    assign irq_o = |(main_cause & st_q.mask);

    // R4: no secondary cause means no summary bit
    a_r4_summary_needs_cause: assert property (@(posedge clk) disable iff (!rst_n)
        (sec_cause == '0) |-> !main_cause[BUSERR_BIT]);

    // R6: mask only changes on a write to its address
    a_r6_mask_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !(reg_wr_i && reg_addr_i == RA_MAIN_MASK) |=> $stable(st_q.mask));

    // R7: empty mask keeps the interrupt low
    a_r7_quiet_when_masked: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.mask == '0) |-> !irq_o);

    // R8: unimplemented bits of main registers read zero
    a_r8_unused_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_addr_i == RA_MAIN_CAUSE || reg_addr_i == RA_MAIN_MASK)
            |-> ((reg_rdata_o & ~VALID) == '0));

endmodule

// File: tb/test_sata_irq_agg.sv
module test_sata_irq_agg;

    localparam int CLK_P = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [7:0]  port_err = '0;
    logic [7:0]  port_done = '0;
    logic [1:0]  coal_done = '0;
    logic [7:0]  bus_err = '0;
    logic [1:0]  addr = '0;
    logic        wr = 1'b0;
    logic [31:0] wdata = '0;
    logic [31:0] rdata, rdata1;
    logic        irq, irq1;

    int checks = 0;
    int errors = 0;
    bit done_flag = 0;

    always #(CLK_P/2) clk = ~clk;

    sata_irq_agg #(.NUM_GROUPS(2), .BUS_ERR_W(8)) i_sata_irq_agg (
        .clk(clk), .rst_n(rst_n), .port_err_i(port_err), .port_done_i(port_done),
        .coal_done_i(coal_done), .bus_err_i(bus_err), .reg_addr_i(addr),
        .reg_wr_i(wr), .reg_wdata_i(wdata), .reg_rdata_o(rdata), .irq_o(irq));

    sata_irq_agg #(.NUM_GROUPS(1), .BUS_ERR_W(8)) i_sata_irq_agg_g1 (
        .clk(clk), .rst_n(rst_n), .port_err_i(port_err), .port_done_i(port_done),
        .coal_done_i(coal_done), .bus_err_i(bus_err), .reg_addr_i(addr),
        .reg_wr_i(wr), .reg_wdata_i(wdata), .reg_rdata_o(rdata1), .irq_o(irq1));

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual 0x%08h expected 0x%08h", req, act, exp);
        end
    endtask

    task automatic tick();
        @(negedge clk);
    endtask

    task automatic wreg(input logic [1:0] a, input logic [31:0] d);
        addr = a; wdata = d; wr = 1'b1;
        tick();
        wr = 1'b0;
    endtask

    task automatic rreg(input logic [1:0] a, output logic [31:0] v, output logic [31:0] v1);
        addr = a; #1;
        v = rdata; v1 = rdata1;
    endtask

    initial begin
        logic [31:0] v, v1, m;
        repeat (3) tick();
        // R10: reset state
        for (int a = 0; a < 4; a++) begin
            rreg(a[1:0], v, v1);
            check("R10 reset read", v, 32'h0);
        end
        check("R10 reset irq", {31'b0, irq}, 32'h0);
        rst_n = 1'b1;
        tick();

        // R6 / R8: mask stores implemented bits only
        wreg(2'd1, 32'hFFFF_FFFF);
        rreg(2'd1, v, v1);
        check("R6 mask readback", v, 32'h0007_FFFF);
        check("R8 one-group mask", v1, 32'h0004_01FF);

        // R1 R2 R3 R7 R8: every source line alone
        for (int k = 0; k < 18; k++) begin
            int h, b, pos;
            h = k / 9; b = k % 9;
            pos = 9*h + b;
            port_err = '0; port_done = '0; coal_done = '0;
            if (b == 8)          coal_done[h] = 1'b1;
            else if (b % 2 == 0) port_err[4*h + b/2] = 1'b1;
            else                 port_done[4*h + b/2] = 1'b1;
            tick();
            rreg(2'd0, v, v1);
            if (b == 8)          check("R3 coalesced bit", v, 32'h1 << pos);
            else if (b % 2 == 0) check("R1 error bit", v, 32'h1 << pos);
            else                 check("R2 done bit", v, 32'h1 << pos);
            check("R8 one-group cause", v1, (h == 0) ? (32'h1 << pos) : 32'h0);
            check("R7 irq unmasked", {31'b0, irq}, 32'h1);
            wreg(2'd1, 32'h0007_FFFF & ~(32'h1 << pos));
            check("R7 irq masked", {31'b0, irq}, 32'h0);
            wreg(2'd1, 32'h0007_FFFF);
        end

        // R7: several lines together, combined pattern
        port_err = 8'h81; port_done = 8'h24; coal_done = 2'b10;
        tick();
        rreg(2'd0, v, v1);
        check("R1 R2 R3 pattern", v, (32'h1 << 0) | (32'h1 << 15) | (32'h1 << 5) |
                                    (32'h1 << 12) | (32'h1 << 17));
        // R9: write to cause ignored
        port_err = '0; port_done = '0; coal_done = '0;
        tick();
        wreg(2'd0, 32'hFFFF_FFFF);
        rreg(2'd0, v, v1);
        check("R9 cause write ignored", v, 32'h0);
        check("R7 irq idle", {31'b0, irq}, 32'h0);

        // R6: per-port done enable by read-modify-write
        wreg(2'd1, 32'h0);
        rreg(2'd1, m, v1);
        wreg(2'd1, m | (32'h1 << 11));
        rreg(2'd1, m, v1);
        wreg(2'd1, m | (32'h1 << 3));
        rreg(2'd1, m, v1);
        wreg(2'd1, m & ~(32'h1 << 11));
        rreg(2'd1, v, v1);
        check("R6 rmw", v, 32'h1 << 3);
        wreg(2'd1, 32'h0004_0000);

        // R11: secondary mask readback
        wreg(2'd3, 32'hFFFF_FF5A);
        rreg(2'd3, v, v1);
        check("R11 sec mask", v, 32'h0000_005A);
        wreg(2'd3, 32'h0);

        // R5: sticky event
        bus_err = 8'hA5; tick(); bus_err = '0;
        repeat (3) tick();
        rreg(2'd2, v, v1);
        check("R5 sticky", v, 32'hA5);
        rreg(2'd0, v, v1);
        check("R4 masked summary", v, 32'h0);
        wreg(2'd3, 32'h04);
        rreg(2'd0, v, v1);
        check("R4 summary set", v, 32'h0004_0000);
        check("R7 irq from summary", {31'b0, irq}, 32'h1);
        wreg(2'd2, 32'hFFFF_FFFB);
        rreg(2'd2, v, v1);
        check("R5 write-zero clear", v, 32'hA1);
        rreg(2'd0, v, v1);
        check("R4 summary cleared", v, 32'h0);
        wreg(2'd2, 32'h0);

        // R4 R5: each secondary bit alone
        for (int i = 0; i < 8; i++) begin
            bus_err = 8'h1 << i; tick(); bus_err = '0;
            wreg(2'd3, 32'h1 << i);
            rreg(2'd0, v, v1);
            check("R4 per-bit summary", v, 32'h0004_0000);
            wreg(2'd3, ~(32'h1 << i) & 32'hFF);
            rreg(2'd0, v, v1);
            check("R4 other bits masked", v, 32'h0);
            wreg(2'd2, ~(32'h1 << i));
            rreg(2'd2, v, v1);
            check("R5 per-bit clear", v, 32'h0);
        end

        // R5: event in the same cycle as a clear write wins
        bus_err = 8'h10; addr = 2'd2; wdata = 32'h0; wr = 1'b1;
        tick();
        wr = 1'b0; bus_err = '0;
        rreg(2'd2, v, v1);
        check("R5 set wins", v, 32'h10);

        done_flag = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        #(CLK_P * 100000);
        if (!done_flag) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual hung expected done");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

endmodule